// File: doc/BRIEF.md
# Paletted Pixel Unpack and Transparent Write

This block moves one pixel per clock from packed texture bytes into a frame buffer. A sequencer presents a source byte together with a 3-bit bit-select and a depth code. The first pipeline stage shifts the byte right by the bit-select, keeps only as many bits as the depth allows (1, 2, 4 or 8), and looks the resulting index up in an internal colour table. The table address is the palette register on the high bits and the index, zero-extended to 8 bits, on the low bits. The same stage flags an index of zero.

The second stage issues the frame-buffer write. Its address is a Y row register joined to a 12-bit X counter. The X counter steps by one for every pixel that passes, including transparent ones. If the index was zero, the write strobe stays low, so colour 0 is transparent. A stall input freezes both stages. The sequencer loads the row, the X start position and the palette register between lines. It fills the colour table through a separate write port.

Top module: `pxl_blit_pipe`

## Requirements
- R1: While reset is asserted, and after it is released until the first pixel is accepted, `fb_we_o` is 0 and `fb_addr_o` is 0.
- R2: The pixel index is (`src_byte_i` >> `bit_sel_i`) masked by the depth code `depth_i`: 0 keeps 1 bit, 1 keeps 2 bits, 2 keeps 4 bits, 3 keeps 8 bits.
- R3: The colour written is the table entry at address {palette register, index zero-extended to 8 bits}.
- R4: A pixel whose index is 0 produces no frame-buffer write.
- R5: The X counter advances by exactly one for each accepted pixel, transparent or not, and wraps from 4095 to 0.
- R6: `fb_addr_o` is {row register, X counter value held by that pixel}. The row register is loaded by `row_ld_i`.
- R7: A pixel is accepted on a clock edge where `in_valid_i` is 1 and `stall_i` is 0. Its write appears on the outputs after the second following accepting edge, and one pixel per clock is sustained.
- R8: While `stall_i` is 1, no pixel is accepted, `fb_we_o` is 0, and `fb_addr_o` is held. The pending write is issued after the stall ends.
- R9: A write through `lut_we_i` stores `lut_wdata_i` at `lut_waddr_i`. A lookup of that address on a later edge returns the stored value.
- R10: `x_ld_i` loads the X counter with `x_start_i`. The pixel accepted next is written at that X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze both stages |
| in_valid_i | input | 1 | Source byte present |
| src_byte_i | input | 8 | Packed source byte |
| bit_sel_i | input | 3 | Right-shift amount |
| depth_i | input | 2 | Depth code (0:1, 1:2, 2:4, 3:8 bits) |
| pal_ld_i | input | 1 | Load palette register |
| pal_i | input | PAL_W | Palette value |
| row_ld_i | input | 1 | Load row register |
| row_i | input | ROW_W | Row value |
| x_ld_i | input | 1 | Load X counter |
| x_start_i | input | X_W | X start value |
| lut_we_i | input | 1 | Colour table write strobe |
| lut_waddr_i | input | PAL_W+8 | Colour table write address |
| lut_wdata_i | input | 8 | Colour table write data |
| fb_we_o | output | 1 | Frame-buffer write strobe |
| fb_addr_o | output | ROW_W+X_W | Frame-buffer address {row, x} |
| fb_data_o | output | 8 | Colour to write |

## Verification
The assertions assume that the row, X and palette loads only arrive while the pipeline is empty. This is because a load that meets a pixel in flight changes that pixel's address or colour, and the X-step property disables itself only for the load cycle. The table-readback property assumes that no second write to the same address lands in between. The stimulus respects both: it drains the pipeline with idle cycles before every load, and it fills the colour table once, before any pixel streams. Stalls are applied with garbage data and valid held high, to show that the stalled inputs are dropped.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2,
    DEPTH_8 = 2'd3
  } depth_e;

  function automatic logic [7:0] depth_mask(depth_e d);
    case (d)
      DEPTH_1: depth_mask = 8'h01;
      DEPTH_2: depth_mask = 8'h03;
      DEPTH_4: depth_mask = 8'h0F;
      default: depth_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/pxl_unpack.sv
module pxl_unpack #(
  parameter int PAL_W = 4,
  localparam int AW = PAL_W + 8
) (
  input  logic [7:0]       byte_i,
  input  logic [2:0]       sel_i,
  input  pxl_pkg::depth_e  depth_i,
  input  logic [PAL_W-1:0] pal_i,
  output logic             zero_o,
  output logic [AW-1:0]    addr_o
);
  logic [7:0] shifted;
  logic [7:0] idx;

  always_comb begin
    shifted = byte_i >> sel_i;
    idx     = shifted & pxl_pkg::depth_mask(depth_i);
    zero_o  = (idx == 8'h00);
    addr_o  = {pal_i, idx};
  end
endmodule

// File: rtl/pxl_clut.sv
module pxl_clut #(
  parameter int AW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    q_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) q_o <= mem[raddr_i];
  end

  // R9: a written entry reads back on a later lookup
  assert_lut_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i ##1 (re_i && !we_i && raddr_i == $past(waddr_i)) |=> q_o == $past(wdata_i, 2));
endmodule

// File: rtl/pxl_fb_wr.sv
module pxl_fb_wr #(
  parameter int ROW_W = 9,
  parameter int X_W   = 12,
  localparam int FA_W = ROW_W + X_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             s1_vld_i,
  input  logic             s1_zero_i,
  input  logic [7:0]       colour_i,
  input  logic             row_ld_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             x_ld_i,
  input  logic [X_W-1:0]   x_start_i,
  output logic             we_o,
  output logic [FA_W-1:0]  addr_o,
  output logic [7:0]       data_o
);
  logic [ROW_W-1:0] row_q, row_d;
  logic [X_W-1:0]   x_q, x_d;
  logic             vld_q, vld_d, zero_q, zero_d;
  logic [FA_W-1:0]  addr_q, addr_d;
  logic [7:0]       data_q, data_d;

  always_comb begin
    row_d  = row_ld_i ? row_i : row_q;
    x_d    = x_q;
    vld_d  = vld_q;
    zero_d = zero_q;
    addr_d = addr_q;
    data_d = data_q;
    if (adv_i) begin
      vld_d  = s1_vld_i;
      zero_d = s1_zero_i;
      if (s1_vld_i) begin
        addr_d = {row_q, x_q};
        data_d = colour_i;
        x_d    = x_q + 1'b1;
      end
    end
    if (x_ld_i) x_d = x_start_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      x_q    <= '0;
      vld_q  <= 1'b0;
      zero_q <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      row_q  <= row_d;
      x_q    <= x_d;
      vld_q  <= vld_d;
      zero_q <= zero_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign we_o   = vld_q & ~zero_q & adv_i;
  assign addr_o = addr_q;
  assign data_o = data_q;

  // R5: one step per accepted pixel
  assert_x_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && s1_vld_i && !x_ld_i) |=> x_q == X_W'($past(x_q) + 1'b1));
  // R10: load lands in the counter
  assert_x_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    x_ld_i |=> x_q == $past(x_start_i));
  // R8: address frozen across a stall
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(addr_o));
endmodule

// File: rtl/pxl_blit_pipe.sv
module pxl_blit_pipe #(
  parameter int PAL_W = 4,
  parameter int ROW_W = 9,
  parameter int X_W   = 12,
  localparam int LA_W = PAL_W + 8,
  localparam int FA_W = ROW_W + X_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             in_valid_i,
  input  logic [7:0]       src_byte_i,
  input  logic [2:0]       bit_sel_i,
  input  logic [1:0]       depth_i,
  input  logic             pal_ld_i,
  input  logic [PAL_W-1:0] pal_i,
  input  logic             row_ld_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             x_ld_i,
  input  logic [X_W-1:0]   x_start_i,
  input  logic             lut_we_i,
  input  logic [LA_W-1:0]  lut_waddr_i,
  input  logic [7:0]       lut_wdata_i,
  output logic             fb_we_o,
  output logic [FA_W-1:0]  fb_addr_o,
  output logic [7:0]       fb_data_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             adv;
  logic [PAL_W-1:0] pal_q, pal_d;
  logic             s1_vld_q, s1_vld_d, s1_zero_q, s1_zero_d;
  logic             un_zero;
  logic [LA_W-1:0]  un_addr;
  logic [7:0]       colour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];
  assign adv       = ~stall_i;

  pxl_unpack #(.PAL_W(PAL_W)) u_unpack (
    .byte_i  (src_byte_i),
    .sel_i   (bit_sel_i),
    .depth_i (pxl_pkg::depth_e'(depth_i)),
    .pal_i   (pal_q),
    .zero_o  (un_zero),
    .addr_o  (un_addr)
  );

  pxl_clut #(.AW(LA_W)) u_clut (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .re_i    (adv),
    .raddr_i (un_addr),
    .q_o     (colour),
    .we_i    (lut_we_i),
    .waddr_i (lut_waddr_i),
    .wdata_i (lut_wdata_i)
  );

  always_comb begin
    pal_d     = pal_ld_i ? pal_i : pal_q;
    s1_vld_d  = s1_vld_q;
    s1_zero_d = s1_zero_q;
    if (adv) begin
      s1_vld_d  = in_valid_i;
      s1_zero_d = un_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pal_q     <= '0;
      s1_vld_q  <= 1'b0;
      s1_zero_q <= 1'b1;
    end else begin
      pal_q     <= pal_d;
      s1_vld_q  <= s1_vld_d;
      s1_zero_q <= s1_zero_d;
    end
  end

  pxl_fb_wr #(.ROW_W(ROW_W), .X_W(X_W)) u_fb_wr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .adv_i     (adv),
    .s1_vld_i  (s1_vld_q),
    .s1_zero_i (s1_zero_q),
    .colour_i  (colour),
    .row_ld_i  (row_ld_i),
    .row_i     (row_i),
    .x_ld_i    (x_ld_i),
    .x_start_i (x_start_i),
    .we_o      (fb_we_o),
    .addr_o    (fb_addr_o),
    .data_o    (fb_data_o)
  );

  // R7: a write needs a pixel accepted two advancing edges earlier
  assert_we_needs_input_R7: assert property (@(posedge clk) disable iff (!rst_n_int)
    (fb_we_o && !$past(stall_i)) |-> $past(s1_vld_q));
endmodule

// File: tb/pxl_blit_pipe_tb.sv
module pxl_blit_pipe_tb;
  localparam int PAL_W = 4;
  localparam int ROW_W = 9;
  localparam int X_W   = 12;
  localparam int LA_W  = PAL_W + 8;
  localparam int FA_W  = ROW_W + X_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall_i = 1'b0, in_valid_i = 1'b0;
  logic [7:0] src_byte_i = '0;
  logic [2:0] bit_sel_i = '0;
  logic [1:0] depth_i = '0;
  logic pal_ld_i = 1'b0, row_ld_i = 1'b0, x_ld_i = 1'b0, lut_we_i = 1'b0;
  logic [PAL_W-1:0] pal_i = '0;
  logic [ROW_W-1:0] row_i = '0;
  logic [X_W-1:0] x_start_i = '0;
  logic [LA_W-1:0] lut_waddr_i = '0;
  logic [7:0] lut_wdata_i = '0;
  logic fb_we_o;
  logic [FA_W-1:0] fb_addr_o;
  logic [7:0] fb_data_o;

  int checks = 0, fails = 0;
  logic monitor_on = 1'b0;
  logic [FA_W+7:0] sb [$];
  logic [PAL_W-1:0] m_pal;
  logic [ROW_W-1:0] m_row;
  logic [X_W-1:0]   m_x;

  always #2 clk = ~clk;

  pxl_blit_pipe #(.PAL_W(PAL_W), .ROW_W(ROW_W), .X_W(X_W)) u_dut (.*);

  function automatic logic [7:0] lut_val(logic [LA_W-1:0] a);
    return 8'((a * 37 + 11) ^ (a >> 4));
  endfunction

  function automatic logic [7:0] dmask(logic [1:0] d);
    case (d)
      2'd0: return 8'h01;
      2'd1: return 8'h03;
      2'd2: return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // driver: one accepted pixel, expected write pushed to the scoreboard
  task automatic px(logic [7:0] b, logic [2:0] s, logic [1:0] d);
    logic [7:0] idx;
    idx = (b >> s) & dmask(d);
    in_valid_i = 1'b1; src_byte_i = b; bit_sel_i = s; depth_i = d;
    if (idx != 0) sb.push_back({m_row, m_x, lut_val({m_pal, idx})}); // R2 R3 R4
    m_x = m_x + 1'b1; // R5
    tick();
    in_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic stall_n(int n);
    stall_i = 1'b1; in_valid_i = 1'b1; src_byte_i = 8'hFF; bit_sel_i = 3'd0; depth_i = 2'd3;
    for (int i = 0; i < n; i++) tick();
    stall_i = 1'b0; in_valid_i = 1'b0;
  endtask

  task automatic setup_line(logic [ROW_W-1:0] r, logic [X_W-1:0] x, logic [PAL_W-1:0] p);
    idle(3);
    row_ld_i = 1'b1; row_i = r; x_ld_i = 1'b1; x_start_i = x; pal_ld_i = 1'b1; pal_i = p;
    tick();
    row_ld_i = 1'b0; x_ld_i = 1'b0; pal_ld_i = 1'b0;
    m_row = r; m_x = x; m_pal = p;
  endtask

  // monitor: pops and compares every write, watches stalls
  always @(negedge clk) begin
    if (monitor_on) begin
      if (stall_i) begin
        checks++;
        if (fb_we_o) begin
          fails++;
          $display("FAIL R8 write during stall: we=%0b expected 0", fb_we_o);
        end
      end
      if (fb_we_o) begin
        checks++;
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL R4 unexpected write addr=%h data=%h expected none", fb_addr_o, fb_data_o);
        end else begin
          logic [FA_W+7:0] e;
          e = sb.pop_front();
          if ({fb_addr_o, fb_data_o} !== e) begin
            fails++;
            $display("FAIL R3 R6 R7 write addr/data=%h expected %h", {fb_addr_o, fb_data_o}, e);
          end
        end
      end
    end
  end

  initial begin
    fork
      begin : wd
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
      end
      begin : run
        idle(3);
        checks++;
        if (fb_we_o !== 1'b0 || fb_addr_o !== '0) begin
          fails++;
          $display("FAIL R1 reset we=%0b addr=%h expected 0/0", fb_we_o, fb_addr_o);
        end
        rst_n = 1'b1;
        idle(4);
        checks++;
        if (fb_we_o !== 1'b0 || fb_addr_o !== '0) begin
          fails++;
          $display("FAIL R1 after reset we=%0b addr=%h expected 0/0", fb_we_o, fb_addr_o);
        end
        // R9: fill the colour table
        for (int a = 0; a < (1 << LA_W); a++) begin
          lut_we_i = 1'b1; lut_waddr_i = LA_W'(a); lut_wdata_i = lut_val(LA_W'(a));
          tick();
        end
        lut_we_i = 1'b0;
        monitor_on = 1'b1;
        // 8-bit depth, zero pixels interleaved (R4, R5)
        setup_line(9'd5, 12'd10, 4'd3);
        px(8'h41, 0, 3); px(8'h00, 0, 3); px(8'hFE, 0, 3); px(8'h80, 3, 3); px(8'h00, 7, 3);
        // 4-bit depth, both nibbles (R2)
        px(8'hA5, 0, 2); px(8'hA5, 4, 2); px(8'h0F, 4, 2); px(8'hF0, 0, 2);
        // stall with garbage in flight (R8)
        px(8'h3C, 2, 2);
        stall_n(3);
        px(8'h77, 1, 2);
        // 2-bit and 1-bit depths
        for (int s = 0; s < 8; s += 2) px(8'b10_01_11_00, 3'(s), 1);
        for (int s = 0; s < 8; s++) px(8'b1010_0110, 3'(s), 0);
        // new row, palette, X (R6, R10)
        setup_line(9'd300, 12'd600, 4'd12);
        px(8'h01, 0, 3); px(8'h55, 1, 0); px(8'hC3, 6, 1);
        stall_n(1);
        px(8'h99, 0, 3);
        // X wrap (R5)
        setup_line(9'd511, 12'd4094, 4'd15);
        px(8'h12, 0, 3); px(8'h34, 0, 3); px(8'h56, 0, 3);
        idle(5);
        checks++;
        if (sb.size() != 0) begin
          fails++;
          $display("FAIL R4 R7 missing writes: %0d pending expected 0", sb.size());
        end
        disable wd;
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule